// File: doc/BRIEF.md
# Bus Hold Arbitration Controller

This block decides when a processor's bus interface hands the local bus to an external master and when it takes the bus back. An outside agent raises a hold request. The controller passes that request through a synchronizer. It grants the bus only on a clock where the core signals an instruction boundary, and only when no locked instruction is in progress. To hand the bus over, it first floats the data and control drivers and then raises the acknowledge one clock later. When the request goes away, it drops the acknowledge first and then re-enables the drivers one clock later. The core may start bus cycles again on that same clock.

The controller also tracks locked instructions. At a boundary where the core marks the next instruction as lock-prefixed, the lock output rises. It stays high for all of that instruction's bus cycles and falls after the core reports the last one. While the lock output is high, and at a boundary that itself opens a locked instruction, hold requests wait. A powerdown input keeps the acknowledge low: it blocks new grants and takes back a bus that is already granted.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After a synchronous reset, the acknowledge `hold_ack` is 0, the driver enable `drv_en` is 1, `core_go` is 1 and `lock_out` is 0.
- R2: A request is granted only on a clock where `insn_edge` is 1. A request held with `insn_edge` at 0 leaves `drv_en` at 1 and `hold_ack` at 0.
- R3: On a grant, `drv_en` and `core_go` fall together while `hold_ack` is still 0. Whenever `hold_ack` is 1, `drv_en` is 0.
- R4: `hold_ack` rises exactly one clock after `drv_en` falls. `hold_req` passes through a two-stage synchronizer. With `insn_edge` held at 1, `drv_en` falls on the third rising edge after `hold_req` rises, and `hold_ack` rises on the fourth.
- R5: After `hold_req` falls, `hold_ack` falls on the third rising edge. `drv_en` and `core_go` return to 1 on the fourth, one clock after `hold_ack` fell.
- R6: At a boundary where `lock_pfx` is 1, `lock_out` becomes 1 on that edge. It stays 1 through the locked bus cycles and becomes 0 on the edge that samples `lock_last` at 1.
- R7: No grant is made while `lock_out` is 1, nor at a boundary where `lock_pfx` is 1. A pending request is granted at the first boundary after `lock_out` has fallen.
- R8: While `pwr_down` is 1, `hold_ack` is 0. Raising `pwr_down` while the bus is granted drops `hold_ack` on the next edge, and no grant is made until `pwr_down` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_req | input | 1 | Asynchronous bus request from an external master, active high |
| insn_edge | input | 1 | Instruction boundary strobe from the core |
| lock_pfx | input | 1 | The instruction starting at this boundary is lock-prefixed |
| lock_last | input | 1 | Last bus cycle of the locked instruction is complete |
| pwr_down | input | 1 | Powerdown mode; forces the acknowledge low |
| hold_ack | output | 1 | Bus granted to the external master |
| drv_en | output | 1 | Enable for the data and control output drivers (0 = floated) |
| core_go | output | 1 | Core may run bus cycles |
| lock_out | output | 1 | A locked bus sequence is in progress |

## Verification
A wrong handover state shows up within one clock as a broken order between `drv_en` and `hold_ack`. Examples are both outputs being active together, or the acknowledge rising without a floated cycle before it. A synchronizer with the wrong depth moves the grant and release edges by whole clocks, so the bench checks the exact edge count from request to float and from request to acknowledge. A lock tracker stuck in the wrong state either lets a grant through in the middle of a locked sequence, or blocks the grant past the first boundary after `lock_last`. Both show on `drv_en` two clocks after the boundary in question.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_FLOAT   = 2'd1,
    ST_HELD    = 2'd2,
    ST_RELEASE = 2'd3
  } hold_state_t;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[LAST-1:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[LAST];
endmodule

// File: rtl/lock_tracker.sv
module lock_tracker (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  input  logic pfx_i,
  input  logic last_i,
  output logic lock_o
);
  logic lock_q;

  always_ff @(posedge clk) begin
    if (rst)                 lock_q <= 1'b0;
    else if (edge_i && pfx_i) lock_q <= 1'b1;
    else if (last_i)         lock_q <= 1'b0;
  end

  assign lock_o = lock_q;

  // R6: the lock opens on a prefixed boundary
  assert_lock_open_R6: assert property (@(posedge clk) disable iff (rst)
    (edge_i && pfx_i) |=> lock_q);

  // R6: the final locked cycle closes the lock
  assert_lock_close_R6: assert property (@(posedge clk) disable iff (rst)
    (last_i && !(edge_i && pfx_i)) |=> !lock_q);
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import bus_hold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic edge_i,
  input  logic pfx_i,
  input  logic lock_i,
  input  logic pwr_i,
  output logic ack_o,
  output logic oe_o,
  output logic go_o
);
  hold_state_t state_q, state_d;
  logic ack_q, oe_q, go_q;
  logic grant_ok;

  assign grant_ok = req_i && edge_i && !pfx_i && !lock_i && !pwr_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (grant_ok) state_d = ST_FLOAT;
      ST_FLOAT:   state_d = pwr_i ? ST_RELEASE : ST_HELD;
      ST_HELD:    if (!req_i || pwr_i) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      ack_q   <= 1'b0;
      oe_q    <= 1'b1;
      go_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_d == ST_HELD);
      oe_q    <= (state_d == ST_RUN);
      go_q    <= (state_d == ST_RUN);
    end
  end

  assign ack_o = ack_q;
  assign oe_o  = oe_q;
  assign go_o  = go_q;

  // R3: drivers are never enabled while the bus is granted
  assert_no_contention_R3: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> !oe_q);

  // R4: acknowledge rises only after a floated, unacknowledged clock
  assert_float_first_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> $past(!oe_q && !ack_q));

  // R5: drivers return only after the acknowledge was already low
  assert_release_order_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> $past(!ack_q && !oe_q));

  // R7: no grant is issued while a lock is active
  assert_lock_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && (lock_i || pfx_i)) |=> oe_q);

  // R8: powerdown keeps the acknowledge low
  assert_pwr_no_ack_R8: assert property (@(posedge clk) disable iff (rst)
    pwr_i |=> !ack_q);
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic insn_edge,
  input  logic lock_pfx,
  input  logic lock_last,
  input  logic pwr_down,
  output logic hold_ack,
  output logic drv_en,
  output logic core_go,
  output logic lock_out
);
  logic req_sync;
  logic lock_act;

  hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i(hold_req),
    .sync_o (req_sync)
  );

  lock_tracker u_lock (
    .clk   (clk),
    .rst   (rst),
    .edge_i(insn_edge),
    .pfx_i (lock_pfx),
    .last_i(lock_last),
    .lock_o(lock_act)
  );

  hold_fsm u_fsm (
    .clk   (clk),
    .rst   (rst),
    .req_i (req_sync),
    .edge_i(insn_edge),
    .pfx_i (lock_pfx),
    .lock_i(lock_act),
    .pwr_i (pwr_down),
    .ack_o (hold_ack),
    .oe_o  (drv_en),
    .go_o  (core_go)
  );

  assign lock_out = lock_act;
endmodule

// File: tb/sim_bus_hold_arbiter.sv
module sim_bus_hold_arbiter;
  logic clk = 1'b0;
  logic rst;
  logic hold_req, insn_edge, lock_pfx, lock_last, pwr_down;
  logic hold_ack, drv_en, core_go, lock_out;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bus_hold_arbiter u0 (
    .clk(clk), .rst(rst), .hold_req(hold_req), .insn_edge(insn_edge),
    .lock_pfx(lock_pfx), .lock_last(lock_last), .pwr_down(pwr_down),
    .hold_ack(hold_ack), .drv_en(drv_en), .core_go(core_go), .lock_out(lock_out)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; hold_req = 0; insn_edge = 0; lock_pfx = 0; lock_last = 0; pwr_down = 0;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "hold_ack", hold_ack, 1'b0);
    chk("R1", "drv_en", drv_en, 1'b1);
    chk("R1", "core_go", core_go, 1'b1);
    chk("R1", "lock_out", lock_out, 1'b0);
  endtask

  task automatic t_grant_release();
    do_reset();
    insn_edge = 1'b1;
    hold_req = 1'b1;
    tick(2);
    chk("R4", "drv_en before third edge", drv_en, 1'b1);
    tick(1);
    chk("R3", "drv_en floated at grant", drv_en, 1'b0);
    chk("R3", "core_go at grant", core_go, 1'b0);
    chk("R3", "hold_ack still low", hold_ack, 1'b0);
    tick(1);
    chk("R4", "hold_ack on fourth edge", hold_ack, 1'b1);
    chk("R3", "drv_en while held", drv_en, 1'b0);
    tick(5);
    chk("R4", "hold_ack sustained", hold_ack, 1'b1);
    hold_req = 1'b0;
    tick(2);
    chk("R5", "hold_ack before third edge", hold_ack, 1'b1);
    tick(1);
    chk("R5", "hold_ack falls", hold_ack, 1'b0);
    chk("R5", "drv_en still floated", drv_en, 1'b0);
    tick(1);
    chk("R5", "drv_en restored", drv_en, 1'b1);
    chk("R5", "core_go restored", core_go, 1'b1);
    insn_edge = 1'b0;
  endtask

  task automatic t_no_boundary();
    do_reset();
    hold_req = 1'b1;
    tick(10);
    chk("R2", "drv_en without boundary", drv_en, 1'b1);
    chk("R2", "hold_ack without boundary", hold_ack, 1'b0);
    insn_edge = 1'b1;
    tick(1);
    insn_edge = 1'b0;
    chk("R2", "drv_en after boundary", drv_en, 1'b0);
    tick(1);
    chk("R2", "hold_ack after boundary", hold_ack, 1'b1);
    hold_req = 1'b0;
    tick(5);
  endtask

  task automatic t_lock();
    do_reset();
    hold_req = 1'b1;
    tick(3);
    insn_edge = 1'b1; lock_pfx = 1'b1;
    tick(1);
    lock_pfx = 1'b0;
    chk("R6", "lock_out set", lock_out, 1'b1);
    chk("R7", "no grant on prefixed boundary", drv_en, 1'b1);
    tick(8);
    chk("R7", "no grant while locked", drv_en, 1'b1);
    chk("R6", "lock_out held", lock_out, 1'b1);
    lock_last = 1'b1;
    tick(1);
    lock_last = 1'b0;
    chk("R6", "lock_out cleared", lock_out, 1'b0);
    chk("R7", "still running at clear edge", drv_en, 1'b1);
    tick(1);
    chk("R7", "grant after lock", drv_en, 1'b0);
    insn_edge = 1'b0;
    hold_req = 1'b0;
    tick(6);
  endtask

  task automatic t_powerdown();
    do_reset();
    insn_edge = 1'b1;
    hold_req = 1'b1;
    tick(4);
    chk("R8", "held before powerdown", hold_ack, 1'b1);
    pwr_down = 1'b1;
    tick(1);
    chk("R8", "hold_ack dropped", hold_ack, 1'b0);
    tick(6);
    chk("R8", "no grant in powerdown", hold_ack, 1'b0);
    chk("R8", "drivers back in powerdown", drv_en, 1'b1);
    pwr_down = 1'b0;
    tick(1);
    chk("R8", "regrant after powerdown", drv_en, 1'b0);
    tick(1);
    chk("R8", "hold_ack after powerdown", hold_ack, 1'b1);
    hold_req = 1'b0;
    insn_edge = 1'b0;
    tick(5);
  endtask

  initial begin
    t_reset();
    t_grant_release();
    t_no_boundary();
    t_lock();
    t_powerdown();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule